// File: doc/BRIEF.md
# Dual-Channel PS/2 Host Register Front End

This block is the register interface for a PS/2 host controller that serves two channels: channel 0 is the keyboard and channel 1 is the mouse. A processor reaches it over a simple bus. A request lasts one cycle, and read data comes back from a register on the following cycle. The channel is chosen by one address bit. Inside each channel's window, only address bits [3:2] choose the register. Toward each device the block gives a receive queue handshake (a not-empty level, a pop strobe and the head byte), a transmit strobe with its byte, and a device interrupt level. The line serialisers and the queues themselves sit outside the block.

Each channel has a loopback mode. In this mode a local one-byte buffer stands in for the device. A transmitted byte is held in the buffer and raises the channel interrupt, and reading the receive register gives the byte back and drops the interrupt. A diagnostic mode makes the two direction bits of the control register show up as the line-shadow bits in the status register. The interrupts of both channels are ORed onto one output.

Top module: `ps2_dual_regs`

## Requirements
- R1: The channel is `busAddr[8]` (0 = keyboard, 1 = mouse). The register is `busAddr[3:2]`. All other address bits are ignored. Reads: 0 = identity, 1 = receive data, 2 = control, 3 = status. Writes: 1 = transmit data, 2 = control.
- R2: An identity read returns 0 on the keyboard channel and 1 on the mouse channel.
- R3: The 8-bit control register reads back exactly the last value written. Its bits are: 0 enable (stored only), 1 loopback, 5 diag, 6 data-direction, 7 clock-direction.
- R4: Status bits 6 (data shadow) and 7 (clock shadow) read 1. The exception is when diag is set: then bit 6 reads 0 if data-direction is clear, and bit 7 reads 0 if clock-direction is clear.
- R5: Outside loopback, a transmit-data write pulses that channel's `devTxStb` in the request cycle, with the byte on `devTxData`.
- R6: Outside loopback, a receive-data read pulses that channel's `devRxPop` once in the request cycle. The head byte of the device appears on `busRdata` one cycle later.
- R7: In loopback, a transmit-data write stores the byte locally and sets both the channel interrupt and the loopback not-empty flag. No device strobe is issued.
- R8: In loopback, a receive-data read returns the stored byte and clears both the channel interrupt and the loopback flag. No device pop is issued.
- R9: Status bit 0 is the loopback flag when loopback is set, and the device's not-empty level otherwise. Status bit 4 is `irqOut`. Bits 1, 2, 3 and 5 read 0.
- R10: `irqOut` is the OR of the two channel interrupts. Outside loopback, a channel interrupt follows its `devIrq` input. This path is combinational.
- R11: Writes to register 0 (reset) and register 3 change no state.
- R12: After reset, every control register is 0, `busRdata` is 0 and both loopback flags are clear.
- R13: `busRdata` changes only after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | One-cycle access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 9 | Byte address; bit 8 channel, bits 3:2 register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| irqOut | output | 1 | Combined interrupt |
| devRxAvail | input | 2 | Per-channel receive queue not empty |
| devRxData | input | 16 | Head bytes, channel n at [8n+7:8n] |
| devRxPop | output | 2 | Per-channel pop strobe |
| devTxStb | output | 2 | Per-channel transmit strobe |
| devTxData | output | 8 | Transmit byte |
| devIrq | input | 2 | Per-channel device interrupt level |

## Verification
The pop and transmit strobes are combinational from the request. The bench therefore counts them at the clock edge that ends the request. Read data is due one edge after the request, so the bench drives each request on a falling edge and samples `busRdata` on the next falling edge. `irqOut` follows `devIrq` combinationally and follows the loopback flag one edge after the access that changes it. The bench checks it shortly after driving the input, or at the falling edge after the access.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;
  localparam int CH_NUM = 2;

  typedef enum logic [1:0] {
    SEL_ID   = 2'd0,
    SEL_RX   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } regSel_t;

  localparam int CTL_LOOP = 1;
  localparam int CTL_DIAG = 5;
  localparam int CTL_DDIR = 6;
  localparam int CTL_CDIR = 7;

  localparam int ST_RBNE = 0;
  localparam int ST_IRQ  = 4;
  localparam int ST_DSHD = 6;
  localparam int ST_CSHD = 7;

  typedef struct packed {
    logic [CH_NUM-1:0] wrCtrl;
    logic [CH_NUM-1:0] wrTx;
    logic [CH_NUM-1:0] rdRx;
    logic              rdEn;
    regSel_t           rdSel;
    logic              rdCh;
  } strobe_t;
endpackage

// File: rtl/ps2r_ctrl.sv
module ps2r_ctrl
  import ps2r_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int WIN_BIT = 8
) (
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  regSel_t sel;
  logic    chIdx;

  assign sel   = regSel_t'(busAddr[3:2]);
  assign chIdx = busAddr[WIN_BIT];

  always_comb begin
    stb.wrCtrl = '0;
    stb.wrTx   = '0;
    stb.rdRx   = '0;
    stb.rdEn   = 1'b0;
    stb.rdSel  = sel;
    stb.rdCh   = chIdx;
    if (busReq) begin
      if (busWrite) begin
        case (sel)
          SEL_RX:   stb.wrTx[chIdx]   = 1'b1;
          SEL_CTRL: stb.wrCtrl[chIdx] = 1'b1;
          default:  ;
        endcase
      end else begin
        stb.rdEn = 1'b1;
        if (sel == SEL_RX) stb.rdRx[chIdx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2r_datapath.sv
module ps2r_datapath
  import ps2r_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  strobe_t                    stb,
  input  logic [DATA_W-1:0]          busWdata,
  input  logic [CH_NUM-1:0]          devRxAvail,
  input  logic [CH_NUM*DATA_W-1:0]   devRxData,
  input  logic [CH_NUM-1:0]          devIrq,
  output logic [CH_NUM-1:0]          devRxPop,
  output logic [CH_NUM-1:0]          devTxStb,
  output logic [DATA_W-1:0]          devTxData,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       irqOut
);
  logic [DATA_W-1:0] ctrlQ  [CH_NUM];
  logic [DATA_W-1:0] lbData [CH_NUM];
  logic [DATA_W-1:0] status [CH_NUM];
  logic [DATA_W-1:0] rxView [CH_NUM];
  logic [CH_NUM-1:0] lbFull;
  logic [CH_NUM-1:0] chanIrq;
  logic [CH_NUM-1:0] loopOn;
  logic [DATA_W-1:0] rdNext;

  assign irqOut    = |chanIrq;
  assign devTxData = busWdata;

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chan
    logic diagOn;
    assign loopOn[ch] = ctrlQ[ch][CTL_LOOP];
    assign diagOn     = ctrlQ[ch][CTL_DIAG];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrlQ[ch]  <= '0;
        lbData[ch] <= '0;
        lbFull[ch] <= 1'b0;
      end else begin
        if (stb.wrCtrl[ch]) ctrlQ[ch] <= busWdata;
        if (stb.wrTx[ch] && loopOn[ch]) begin
          lbData[ch] <= busWdata;
          lbFull[ch] <= 1'b1;
        end else if (stb.rdRx[ch] && loopOn[ch]) begin
          lbFull[ch] <= 1'b0;
        end
      end
    end

    assign chanIrq[ch]  = loopOn[ch] ? lbFull[ch] : devIrq[ch];
    assign devTxStb[ch] = stb.wrTx[ch] && !loopOn[ch];
    assign devRxPop[ch] = stb.rdRx[ch] && !loopOn[ch];
    assign rxView[ch]   = loopOn[ch] ? lbData[ch] : devRxData[ch*DATA_W +: DATA_W];

    always_comb begin
      status[ch]          = '0;
      status[ch][ST_DSHD] = !(diagOn && !ctrlQ[ch][CTL_DDIR]);
      status[ch][ST_CSHD] = !(diagOn && !ctrlQ[ch][CTL_CDIR]);
      status[ch][ST_RBNE] = loopOn[ch] ? lbFull[ch] : devRxAvail[ch];
      status[ch][ST_IRQ]  = irqOut;
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_ID:   rdNext = DATA_W'(stb.rdCh);
      SEL_RX:   rdNext = rxView[stb.rdCh];
      SEL_CTRL: rdNext = ctrlQ[stb.rdCh];
      SEL_STAT: rdNext = status[stb.rdCh];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdNext;
  end
endmodule

// File: rtl/ps2_dual_regs.sv
module ps2_dual_regs
  import ps2r_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int WIN_BIT = 8,
  parameter int DATA_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busReq,
  input  logic                     busWrite,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output logic                     irqOut,
  input  logic [CH_NUM-1:0]        devRxAvail,
  input  logic [CH_NUM*DATA_W-1:0] devRxData,
  output logic [CH_NUM-1:0]        devRxPop,
  output logic [CH_NUM-1:0]        devTxStb,
  output logic [DATA_W-1:0]        devTxData,
  input  logic [CH_NUM-1:0]        devIrq
);
  strobe_t stb;

  ps2r_ctrl #(.ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT)) u_ctrl (
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .stb(stb)
  );

  ps2r_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busWdata(busWdata),
    .devRxAvail(devRxAvail), .devRxData(devRxData), .devIrq(devIrq),
    .devRxPop(devRxPop), .devTxStb(devTxStb), .devTxData(devTxData),
    .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/ps2r_checker.sv
module ps2r_checker
  import ps2r_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int WIN_BIT = 8,
  parameter int DATA_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busReq,
  input logic                     busWrite,
  input logic [ADDR_W-1:0]        busAddr,
  input logic [DATA_W-1:0]        busWdata,
  input logic [DATA_W-1:0]        busRdata,
  input logic                     irqOut,
  input logic [CH_NUM-1:0]        devRxAvail,
  input logic [CH_NUM*DATA_W-1:0] devRxData,
  input logic [CH_NUM-1:0]        devRxPop,
  input logic [CH_NUM-1:0]        devTxStb,
  input logic [DATA_W-1:0]        devTxData,
  input logic [CH_NUM-1:0]        devIrq
);
  AST_POP_ONLY_ON_RX_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (devRxPop != '0) |-> (busReq && !busWrite && busAddr[3:2] == 2'd1)); // R6

  AST_TX_ONLY_ON_TX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (devTxStb != '0) |-> (busReq && busWrite && busAddr[3:2] == 2'd1 && devTxData == busWdata)); // R5

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({devRxPop, devTxStb})); // R1

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && !busWrite && busAddr[3:2] == 2'd0) |=> (busRdata == DATA_W'($past(busAddr[WIN_BIT])))); // R2

  AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && !busWrite && busAddr[3:2] == 2'd3) |=> (busRdata[3:1] == 3'b000 && busRdata[5] == 1'b0)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busReq || busWrite) |=> $stable(busRdata)); // R13
endmodule

bind ps2_dual_regs ps2r_checker #(.ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT), .DATA_W(DATA_W)) chk (.*);

// File: tb/ps2_dual_regs_test.sv
module ps2_dual_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busReq = 1'b0;
  logic        busWrite = 1'b0;
  logic [8:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        irqOut;
  logic [1:0]  devRxAvail = '0;
  logic [15:0] devRxData = '0;
  logic [1:0]  devRxPop;
  logic [1:0]  devTxStb;
  logic [7:0]  devTxData;
  logic [1:0]  devIrq = '0;

  int checks = 0;
  int failures = 0;
  int popCnt [2];
  int txCnt [2];
  logic [7:0] lastTx [2];

  always #2.5 clk = ~clk;

  ps2_dual_regs uut (
    .clk(clk), .rst_n(rst_n), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .devRxAvail(devRxAvail), .devRxData(devRxData), .devRxPop(devRxPop),
    .devTxStb(devTxStb), .devTxData(devTxData), .devIrq(devIrq)
  );

  initial begin
    popCnt = '{0, 0};
    txCnt = '{0, 0};
    lastTx = '{8'h00, 8'h00};
  end

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (devRxPop[i]) popCnt[i] = popCnt[i] + 1;
      if (devTxStb[i]) begin
        txCnt[i] = txCnt[i] + 1;
        lastTx[i] = devTxData;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit ch, input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    busReq = 1'b1;
    busWrite = wr;
    busAddr = {ch, off};
    busWdata = d;
    @(negedge clk);
    busReq = 1'b0;
    busWrite = 1'b0;
  endtask

  task automatic wr(input bit ch, input logic [7:0] off, input logic [7:0] d);
    access(1'b1, ch, off, d);
  endtask

  task automatic rd(input bit ch, input logic [7:0] off, output logic [7:0] d);
    access(1'b0, ch, off, 8'h00);
    d = busRdata;
  endtask

  function automatic logic [7:0] expStat(logic [7:0] c, logic avail, logic lbf, logic irq);
    logic [7:0] s;
    s = '0;
    s[6] = !(c[5] && !c[6]);
    s[7] = !(c[5] && !c[7]);
    s[0] = c[1] ? lbf : avail;
    s[4] = irq;
    return s;
  endfunction

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int p0, t0, t1;
    repeat (3) @(negedge clk);
    check("R12 rdata at reset", busRdata, 0);
    check("R12 irq at reset", irqOut, 0);
    rst_n = 1'b1;
    rd(0, 8'h08, d); check("R12 kbd control reset", d, 0);
    rd(1, 8'h08, d); check("R12 mouse control reset", d, 0);
    rd(1, 8'h0C, d); check("R12 mouse status reset", d, 8'hC0);

    rd(0, 8'h00, d); check("R2 kbd id", d, 0);
    rd(1, 8'h00, d); check("R2 mouse id", d, 1);

    // Sweep every control value on both channels: R3 readback, R4/R9 status
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 256; v++) begin
        devRxAvail[ch] = v[3];
        wr(ch[0], 8'h08, v[7:0]);
        rd(ch[0], 8'h08, d); check("R3 control readback", d, v);
        rd(ch[0], 8'h0C, d); check("R4 R9 status", d, expStat(v[7:0], v[3], 1'b0, 1'b0));
      end
      wr(ch[0], 8'h08, 8'h00);
      devRxAvail[ch] = 1'b0;
    end

    // R1: aliased addresses
    wr(1, 8'hF9, 8'h61);
    rd(1, 8'h4B, d); check("R1 alias control mouse", d, 8'h61);
    rd(0, 8'h08, d); check("R1 other channel untouched", d, 0);
    rd(1, 8'h73, d); check("R1 alias id", d, 1);
    wr(1, 8'h08, 8'h00);

    // R11: reset and offset-12 writes change nothing
    wr(0, 8'h08, 8'h25);
    wr(0, 8'h00, 8'hFF);
    wr(0, 8'h0C, 8'hFF);
    rd(0, 8'h08, d); check("R11 control kept", d, 8'h25);
    rd(0, 8'h0C, d); check("R11 status kept", d, expStat(8'h25, 1'b0, 1'b0, 1'b0));
    wr(0, 8'h08, 8'h00);

    // R5: device transmit path
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 4; k++) begin
        t0 = txCnt[ch]; t1 = txCnt[1-ch];
        wr(ch[0], 8'h04, 8'(8'h3C + k * 37));
        check("R5 tx strobe count", txCnt[ch], t0 + 1);
        check("R5 tx byte", lastTx[ch], 8'(8'h3C + k * 37));
        check("R5 other channel silent", txCnt[1-ch], t1);
      end
    end

    // R6: device receive path
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 4; k++) begin
        devRxAvail[ch] = 1'b1;
        devRxData[ch*8 +: 8] = 8'(8'h91 ^ (k * 19) ^ ch);
        p0 = popCnt[ch];
        rd(ch[0], 8'h04, d);
        check("R6 rx data", d, 8'(8'h91 ^ (k * 19) ^ ch));
        check("R6 single pop", popCnt[ch], p0 + 1);
      end
      devRxAvail[ch] = 1'b0;
    end

    // R10: device interrupts
    devIrq = 2'b10; #1;
    check("R10 mouse irq", irqOut, 1);
    rd(0, 8'h0C, d); check("R9 irq pending seen on kbd", d[4], 1);
    devIrq = 2'b01; #1;
    check("R10 kbd irq", irqOut, 1);
    devIrq = 2'b00; #1;
    check("R10 irq low", irqOut, 0);

    // R7/R8: loopback on keyboard
    wr(0, 8'h08, 8'h02);
    t0 = txCnt[0]; p0 = popCnt[0];
    wr(0, 8'h04, 8'hA5);
    check("R7 no device tx", txCnt[0], t0);
    check("R7 irq set", irqOut, 1);
    rd(0, 8'h0C, d); check("R7 R9 status loop full", d, expStat(8'h02, 1'b0, 1'b1, 1'b1));
    rd(1, 8'h0C, d); check("R9 mouse sees pending", d[4], 1);
    devRxAvail[0] = 1'b1;
    rd(0, 8'h04, d); check("R8 loop data", d, 8'hA5);
    check("R8 no device pop", popCnt[0], p0);
    check("R8 irq cleared", irqOut, 0);
    rd(0, 8'h0C, d); check("R8 R9 status loop empty", d, expStat(8'h02, 1'b1, 1'b0, 1'b0));
    devRxAvail[0] = 1'b0;

    // R10: loopback masks device irq
    devIrq = 2'b01; #1;
    check("R10 loop masks device irq", irqOut, 0);
    wr(0, 8'h08, 8'h00); #1;
    check("R10 device irq back", irqOut, 1);
    devIrq = 2'b00;

    // R13: writes do not disturb read data
    rd(1, 8'h00, d);
    wr(1, 8'h08, 8'h80);
    check("R13 rdata held", busRdata, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule